// File: doc/BRIEF.md
# Reconfigurable Systolic Convolution Engine

This block evaluates a two-dimensional convolution at stride 1 with a square kernel whose size is chosen at run time: 5×5, 3×3 or 1×1. One datapath serves all three sizes. It holds `KMAX` row units, and each row unit is a chain of `KMAX` multiply-accumulate cells. Each cell multiplies the current sample by its own weight, adds the partial sum handed over by the previous cell and registers the result for the next cell. The bias enters the first cell of the first row only. The outputs of the active rows are added into one registered result.

A controller first loads every kernel weight and the bias through a write port. It then streams the feature map. On each clock it presents one signed sample per row unit, with row unit r receiving the sample of the r-th input line that the kernel currently covers. All cells of a row see the same sample, so a new window starts on every clock. Once the chain is full, the block delivers one result per clock with a valid strobe. Cells and rows beyond the selected size are left out of the result.

Top module: `conv_mac_array`

## Requirements
- R1: While reset is asserted and after it is released with no input, `out_valid` is 0 and `out_data` is 0.
- R2: `mode` selects the kernel size K: 2'b00 gives 1×1, 2'b01 gives 3×3, 2'b10 gives 5×5, and 2'b11 is handled as 1×1.
- R3: When `wload_en` is high, the weight at row `wload_sel / KMAX` and column `wload_sel % KMAX` takes `wload_val`. When `bias_load_en` is high, the bias takes `bias_val`. Both values hold until they are loaded again.
- R4: For accepted samples s(t) (row r of sample t is `in_x[r*DATA_W +: DATA_W]`), the window that starts at sample t gives bias + Σ over r<K and j<K of w[r][j]·x_r(t+j), where column j multiplies the j-th oldest sample of the window.
- R5: The bias is counted exactly once per result, whatever the value of K.
- R6: Weights in rows or columns at index ≥ K, and samples on row inputs at index ≥ K, have no effect on the result.
- R7: The result of a window whose last sample is accepted on clock edge e appears with `out_valid` high after edge e+1. With continuous input, one result follows on every clock.
- R8: A result is produced only when all K samples of its window were accepted with `in_valid` high. While `out_valid` is low, `out_data` keeps its previous value.
- R9: A clock edge on which `mode` differs from the previous edge discards the sample history, including that edge's sample. The next valid result then needs K fresh samples under the new mode.
- R10: Arithmetic is two's complement and keeps full precision: `out_data` is ACC_W = DATA_W+WGT_W+clog2(KMAX²)+1 bits wide, so extreme operands do not overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Kernel size select |
| wload_en | input | 1 | Weight write strobe |
| wload_sel | input | clog2(KMAX²) | Flat weight index, row-major |
| wload_val | input | WGT_W | Signed weight value |
| bias_load_en | input | 1 | Bias write strobe |
| bias_val | input | BIAS_W | Signed bias value |
| in_valid | input | 1 | Sample word accepted this clock |
| in_x | input | KMAX·DATA_W | One signed sample per row unit |
| out_valid | output | 1 | Result strobe |
| out_data | output | ACC_W | Signed convolution result |

## Verification
A corrupted partial sum in one cell spoils every window that passes through that cell. It therefore shows up as a wrong `out_data` within K+1 clocks and keeps recurring while the stream runs. A valid-history register that is stale or not cleared shows at the ports as a strobe one clock early or late, or as a strobe for a window that spans a gap or a mode switch. Those errors appear on the first window that crosses the fault. Tap or row gating that includes the wrong cells appears only when the unused weights and row inputs carry nonzero values, so the bench fills them on purpose.

// File: rtl/conv_mac_pkg.sv
package conv_mac_pkg;

   typedef enum logic [1:0] {
      KSEL_1X1 = 2'b00,
      KSEL_3X3 = 2'b01,
      KSEL_5X5 = 2'b10,
      KSEL_ALT = 2'b11
   } ksel_e;

   // Active kernel edge length for a mode code (R2)
   function automatic int ksel_size(input logic [1:0] code);
      case (ksel_e'(code))
         KSEL_3X3: return 3;
         KSEL_5X5: return 5;
         default:  return 1;
      endcase
   endfunction

endpackage

// File: rtl/conv_pe.sv
module conv_pe #(
   parameter int DATA_W = 8,
   parameter int WGT_W  = 8,
   parameter int ACC_W  = 22
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [DATA_W-1:0] x,
   input  logic signed [WGT_W-1:0]  w,
   input  logic signed [ACC_W-1:0]  psum_in,
   output logic signed [ACC_W-1:0]  psum_out
);
   localparam int PROD_W = DATA_W + WGT_W;

   logic signed [PROD_W-1:0] prod;

   assign prod = x * w;

   always_ff @(posedge clk) begin
      if (!rst_n) psum_out <= '0;
      else        psum_out <= psum_in + ACC_W'(prod);
   end
endmodule

// File: rtl/conv_row.sv
module conv_row #(
   parameter int KMAX   = 5,
   parameter int DATA_W = 8,
   parameter int WGT_W  = 8,
   parameter int ACC_W  = 22,
   parameter int TAP_W  = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [DATA_W-1:0] x,
   input  logic signed [WGT_W-1:0]  w [KMAX],
   input  logic signed [ACC_W-1:0]  bias_in,
   input  logic        [TAP_W-1:0]  tap_sel,
   output logic signed [ACC_W-1:0]  tap
);
   logic signed [ACC_W-1:0] chain [KMAX+1];

   assign chain[0] = bias_in;

   for (genvar j = 0; j < KMAX; j++) begin : g_pe
      conv_pe #(
         .DATA_W(DATA_W),
         .WGT_W (WGT_W),
         .ACC_W (ACC_W)
      ) u_pe (
         .clk     (clk),
         .rst_n   (rst_n),
         .x       (x),
         .w       (w[j]),
         .psum_in (chain[j]),
         .psum_out(chain[j+1])
      );
   end

   // Pick the cell that closes a K-long chain
   always_comb begin
      tap = '0;
      for (int j = 0; j < KMAX; j++) begin
         if (int'(tap_sel) == j) tap = chain[j+1];
      end
   end
endmodule

// File: rtl/conv_mac_array.sv
module conv_mac_array
   import conv_mac_pkg::*;
#(
   parameter int KMAX   = 5,
   parameter int DATA_W = 8,
   parameter int WGT_W  = 8,
   parameter int BIAS_W = 16,
   localparam int NW    = KMAX * KMAX,
   localparam int SEL_W = $clog2(NW),
   localparam int ACC_W = DATA_W + WGT_W + $clog2(NW) + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               mode,
   input  logic                     wload_en,
   input  logic [SEL_W-1:0]         wload_sel,
   input  logic [WGT_W-1:0]         wload_val,
   input  logic                     bias_load_en,
   input  logic [BIAS_W-1:0]        bias_val,
   input  logic                     in_valid,
   input  logic [KMAX*DATA_W-1:0]   in_x,
   output logic                     out_valid,
   output logic [ACC_W-1:0]         out_data
);
   localparam int TAP_W = $clog2(KMAX);

   if (KMAX < 5) begin : g_bad_kmax
      $error("conv_mac_array: KMAX must cover the 5x5 mode");
   end
   if (BIAS_W > ACC_W - 1) begin : g_bad_bias
      $error("conv_mac_array: BIAS_W exceeds accumulator headroom");
   end
   if (DATA_W < 2 || WGT_W < 2) begin : g_bad_width
      $error("conv_mac_array: operand widths too small");
   end

   logic signed [WGT_W-1:0]  w_q [KMAX][KMAX];
   logic signed [BIAS_W-1:0] bias_q;
   logic [1:0]               mode_q;
   logic [KMAX-1:0]          vhist;
   int                       kact;
   logic [TAP_W-1:0]         tap_sel;
   logic signed [ACC_W-1:0]  row_tap [KMAX];
   logic signed [ACC_W-1:0]  row_sum;
   logic                     win_ok;

   // Parameter store (R3)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bias_q <= '0;
         for (int r = 0; r < KMAX; r++)
            for (int c = 0; c < KMAX; c++)
               w_q[r][c] <= '0;
      end else begin
         if (bias_load_en) bias_q <= bias_val;
         if (wload_en) begin
            for (int r = 0; r < KMAX; r++)
               for (int c = 0; c < KMAX; c++)
                  if (int'(wload_sel) == r * KMAX + c) w_q[r][c] <= wload_val;
         end
      end
   end

   // Mode register and window history (R8, R9)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= 2'b00;
         vhist  <= '0;
      end else begin
         mode_q <= mode;
         if (mode != mode_q) vhist <= '0;
         else                vhist <= {vhist[KMAX-2:0], in_valid};
      end
   end

   assign kact    = ksel_size(mode_q);
   assign tap_sel = TAP_W'(kact - 1);

   for (genvar r = 0; r < KMAX; r++) begin : g_row
      logic signed [ACC_W-1:0] bias_row;
      if (r == 0) begin : g_bias
         assign bias_row = ACC_W'(bias_q);
      end else begin : g_nobias
         assign bias_row = '0;
      end

      conv_row #(
         .KMAX  (KMAX),
         .DATA_W(DATA_W),
         .WGT_W (WGT_W),
         .ACC_W (ACC_W),
         .TAP_W (TAP_W)
      ) u_row (
         .clk    (clk),
         .rst_n  (rst_n),
         .x      (in_x[r*DATA_W +: DATA_W]),
         .w      (w_q[r]),
         .bias_in(bias_row),
         .tap_sel(tap_sel),
         .tap    (row_tap[r])
      );
   end

   // Rows beyond the active size contribute nothing (R6)
   always_comb begin
      row_sum = '0;
      for (int r = 0; r < KMAX; r++)
         if (r < kact) row_sum = row_sum + row_tap[r];
   end

   always_comb begin
      win_ok = 1'b1;
      for (int i = 0; i < KMAX; i++)
         if (i < kact && !vhist[i]) win_ok = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= win_ok;
         if (win_ok) out_data <= row_sum;
      end
   end
endmodule

// File: rtl/conv_mac_array_chk.sv
module conv_mac_array_chk #(
   parameter int ACC_W = 22
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode,
   input logic             in_valid,
   input logic             out_valid,
   input logic [ACC_W-1:0] out_data
);
   // R7: a strobe needs the last window sample two edges back
   p_valid_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2));

   // R7: in 5x5 mode the oldest window sample sits six edges back
   p_k5_depth_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(mode, 2) == 2'b10) |-> $past(in_valid, 6));

   // R9: a mode switch kills the following strobe
   p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != $past(mode)) |-> ##2 !out_valid);

   // R8: data holds without a strobe
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data));
endmodule

bind conv_mac_array conv_mac_array_chk #(.ACC_W(ACC_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode     (mode),
   .in_valid (in_valid),
   .out_valid(out_valid),
   .out_data (out_data)
);

// File: tb/conv_mac_array_bench.sv
module conv_mac_array_bench;
   localparam int KMAX   = 5;
   localparam int DATA_W = 8;
   localparam int WGT_W  = 8;
   localparam int BIAS_W = 16;
   localparam int SEL_W  = 5;
   localparam int ACC_W  = 22;
   localparam int MAXS   = 4096;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic [1:0]             mode = 2'b00;
   logic                   wload_en = 1'b0;
   logic [SEL_W-1:0]       wload_sel = '0;
   logic [WGT_W-1:0]       wload_val = '0;
   logic                   bias_load_en = 1'b0;
   logic [BIAS_W-1:0]      bias_val = '0;
   logic                   in_valid = 1'b0;
   logic [KMAX*DATA_W-1:0] in_x = '0;
   logic                   out_valid;
   logic [ACC_W-1:0]       out_data;

   always #5 clk = ~clk;

   conv_mac_array u_conv_mac_array (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .wload_en(wload_en), .wload_sel(wload_sel), .wload_val(wload_val),
      .bias_load_en(bias_load_en), .bias_val(bias_val),
      .in_valid(in_valid), .in_x(in_x),
      .out_valid(out_valid), .out_data(out_data)
   );

   int     checks = 0;
   int     failures = 0;
   bit     done = 1'b0;
   string  tag = "R1";
   int     idx = 0;
   int     xs [MAXS][KMAX];
   bit     vs [MAXS];
   int     ms [MAXS];
   int     wb [KMAX][KMAX];
   int     biasb = 0;
   longint last_out = 0;
   int     nvalid = 0;

   function automatic int ksz(input int m);
      return (m == 1) ? 3 : (m == 2) ? 5 : 1;
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d sample=%0d", req, act, exp, idx);
      end
   endtask

   // Window ending at sample L is visible at this negedge
   task automatic evaluate();
      int     L;
      int     k;
      bit     ok;
      longint e;
      L = idx - 2;
      if (L < 0 || !rst_n) return;
      k  = ksz(ms[L]);
      ok = (L - k + 1 >= 1);
      if (ok) begin
         for (int s = L - k + 1; s <= L; s++)
            if (!vs[s] || ms[s] != ms[s-1]) ok = 1'b0;
      end
      chk({tag, " strobe"}, longint'(out_valid), longint'(ok));
      if (ok) begin
         e = biasb;
         for (int r = 0; r < k; r++)
            for (int j = 0; j < k; j++)
               e += longint'(wb[r][j]) * longint'(xs[L-k+1+j][r]);
         chk({tag, " data"}, longint'($signed(out_data)), e);
         nvalid++;
      end else if (!out_valid) begin
         chk("R8 hold", longint'($signed(out_data)), last_out);
      end
      last_out = longint'($signed(out_data));
   endtask

   task automatic step();
      for (int r = 0; r < KMAX; r++) xs[idx][r] = int'($signed(in_x[r*DATA_W +: DATA_W]));
      vs[idx] = in_valid && rst_n;
      ms[idx] = int'(mode);
      if (rst_n && wload_en)
         wb[int'(wload_sel) / KMAX][int'(wload_sel) % KMAX] = int'($signed(wload_val));
      if (rst_n && bias_load_en) biasb = int'($signed(bias_val));
      idx++;
      @(negedge clk);
      evaluate();
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic load_w(input int r, input int c, input int v);
      wload_en = 1'b1; wload_sel = SEL_W'(r * KMAX + c); wload_val = WGT_W'(v);
      step();
      wload_en = 1'b0;
   endtask

   task automatic load_b(input int v);
      bias_load_en = 1'b1; bias_val = BIAS_W'(v);
      step();
      bias_load_en = 1'b0;
   endtask

   task automatic load_rand();
      for (int r = 0; r < KMAX; r++)
         for (int c = 0; c < KMAX; c++)
            load_w(r, c, int'($urandom_range(0, 255)) - 128);
      load_b(int'($urandom_range(0, 65535)) - 32768);
   endtask

   task automatic load_const(input int v, input int b);
      for (int r = 0; r < KMAX; r++)
         for (int c = 0; c < KMAX; c++)
            load_w(r, c, v);
      load_b(b);
   endtask

   // gap = 0 streams continuously; else every gap-th sample is dropped
   task automatic stream(input int n, input int gap, input int fixed, input bit use_fixed);
      for (int i = 0; i < n; i++) begin
         in_valid = (gap == 0) ? 1'b1 : ((i % gap) != gap - 1);
         for (int r = 0; r < KMAX; r++)
            in_x[r*DATA_W +: DATA_W] = use_fixed ? DATA_W'(fixed) : DATA_W'($urandom_range(0, 255));
         step();
      end
      in_valid = 1'b0;
   endtask

   initial begin
      for (int r = 0; r < KMAX; r++)
         for (int c = 0; c < KMAX; c++)
            wb[r][c] = 0;
      @(negedge clk);
      idle(4);
      rst_n = 1'b1;
      idle(3);
      // R1: quiet after reset
      chk("R1 valid", longint'(out_valid), 0);
      chk("R1 data", longint'(out_data), 0);

      tag = "R4"; mode = 2'b10; idle(3);
      load_rand(); idle(2);
      stream(60, 0, 0, 0); idle(4);

      tag = "R8"; stream(60, 7, 0, 0); idle(4);
      stream(40, 3, 0, 0); idle(4);

      tag = "R6"; mode = 2'b01; idle(3);
      stream(60, 0, 0, 0); idle(4);

      tag = "R2"; mode = 2'b00; idle(3);
      stream(30, 0, 0, 0); idle(4);
      mode = 2'b11; idle(3);
      stream(30, 0, 0, 0); idle(4);

      tag = "R5"; mode = 2'b10; idle(3);
      load_const(0, -777); idle(2);
      stream(20, 0, 0, 0); idle(4);
      mode = 2'b01; idle(3);
      stream(20, 0, 0, 0); idle(4);

      tag = "R10"; mode = 2'b10; idle(3);
      load_const(-128, 32767); idle(2);
      stream(20, 0, -128, 1); idle(4);
      load_const(-128, -32768); idle(2);
      stream(20, 0, 127, 1); idle(4);

      tag = "R7"; load_rand(); idle(2);
      nvalid = 0;
      stream(5, 0, 0, 0); idle(6);
      chk("R7 one result from five samples", nvalid, 1);
      nvalid = 0;
      stream(4, 0, 0, 0); idle(6);
      chk("R7 no result from four samples", nvalid, 0);

      tag = "R9"; mode = 2'b01; idle(3);
      in_valid = 1'b1;
      for (int i = 0; i < 20; i++) begin
         for (int r = 0; r < KMAX; r++) in_x[r*DATA_W +: DATA_W] = DATA_W'($urandom_range(0, 255));
         if (i == 10) mode = 2'b10;
         if (i == 16) mode = 2'b00;
         step();
      end
      in_valid = 1'b0; idle(4);

      tag = "R3"; mode = 2'b00; idle(3);
      load_w(0, 0, 93); idle(2);
      stream(10, 0, 0, 0); idle(4);
      load_w(0, 0, -5); idle(2);
      stream(10, 0, 0, 0); idle(4);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule